// File: doc/BRIEF.md
# Address Translation Result Register

This block owns the 64-bit register in which software finds the outcome of an address translation request. A translation operation arrives on a valid/ready stream. It carries a 32-bit virtual address and a 2-bit operation selector. The block forwards the address, a write flag and a user/privileged flag to an external table walker over a second valid/ready stream. It then waits for the walker's response. The response carries either a physical address or a fault status. The block encodes that response into the register, in one of two layouts chosen by the `long_fmt` mode input. The walker and the reporting of memory attributes are outside this block.

Software can also write the register directly. A 32-bit write goes to the low half and is masked according to the current mode and architecture level. A 64-bit write replaces both halves. The register is always visible on `result`. Back-pressure works as follows. An operation is accepted only in a cycle where both `op_valid` and `op_ready` are high, and `op_ready` stays low while an operation is outstanding. A walker request, once raised, holds its payload until `wreq_ready` is seen. A response is taken only while `wrsp_ready` is high.

Top module: `xlat_result_reg`

## Requirements
- R1: Reset clears all 64 bits of `result`, raises `op_ready` and lowers `wreq_valid` and `wrsp_ready`.
- R2: An accepted operation raises `wreq_valid` on the next cycle. The request carries `op_va` as `wreq_va`, `op_sel[0]` as `wreq_write` and `op_sel[1]` as `wreq_user`, and the payload stays unchanged until the cycle in which `wreq_ready` is high.
- R3: From acceptance until the response handshake, `op_ready` is low, so at most one operation is outstanding.
- R4: `result` keeps its previous value while an operation waits. It takes the encoded response on the clock edge of the response handshake (`wrsp_valid` and `wrsp_ready` both high).
- R5: In long mode a successful response yields bit 11 set and bits [39:12] equal to `wrsp_pa[39:12]`. Every other bit is zero, and `wrsp_super` is ignored.
- R6: In long mode a fault yields bit 11 and bit 0 set and bits [6:1] equal to `wrsp_status[5:0]`. Every other bit is zero.
- R7: In short mode a successful response that is not a supersection, or any success when `new_arch` is low, yields bits [31:12] equal to `wrsp_pa[31:12]`. Every other bit, including the whole upper half, is zero.
- R8: In short mode with `new_arch` high, a successful supersection response (`wrsp_super` high) yields bits [31:24] equal to `wrsp_pa[31:24]` and bit 1 set. Every other bit is zero.
- R9: In short mode a fault yields bit 0 set, bits [4:1] equal to `wrsp_status[3:0]`, bit 5 equal to `wrsp_status[10]` and bit 6 equal to `wrsp_status[12]`. Every other bit is zero.
- R10: A 32-bit write (`reg_wr32`) in long mode copies `reg_wdata[31:0]` unmasked into the low half and leaves the upper half unchanged.
- R11: A 32-bit write in short mode stores `reg_wdata[31:0]` ANDed with 0xFFFFF6FF when `new_arch` is high, or with 0xFFFFF1FF when it is low. The upper half is unchanged.
- R12: A 64-bit write (`reg_wr64`) loads all of `reg_wdata`. It takes precedence over a 32-bit write in the same cycle, and a response load takes precedence over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| long_fmt | input | 1 | 1 selects the long result layout |
| new_arch | input | 1 | 1 selects the newer architecture level for short layout |
| op_valid | input | 1 | Translation operation valid |
| op_ready | output | 1 | Operation can be accepted |
| op_va | input | 32 | Virtual address to translate |
| op_sel | input | 2 | Bit 0 write access, bit 1 user access |
| wreq_valid | output | 1 | Request to walker valid |
| wreq_ready | input | 1 | Walker accepts request |
| wreq_va | output | 32 | Virtual address to walker |
| wreq_write | output | 1 | Write access flag to walker |
| wreq_user | output | 1 | User access flag to walker |
| wrsp_valid | input | 1 | Walker response valid |
| wrsp_ready | output | 1 | Block waits for a response |
| wrsp_fault | input | 1 | Response is a fault |
| wrsp_super | input | 1 | Success mapped a 16 MiB supersection |
| wrsp_status | input | 13 | Fault status from walker |
| wrsp_pa | input | 40 | Physical address from walker |
| reg_wr32 | input | 1 | Direct 32-bit write strobe |
| reg_wr64 | input | 1 | Direct 64-bit write strobe |
| reg_wdata | input | 64 | Direct write data |
| result | output | 64 | Current register contents |

## Verification
The hardest case to reach from the ports is a response encoded with the mode inputs in an unusual combination. One example is a supersection flag on a long-mode success. Another is a short-mode fault whose status has its relocated high bits set along with bits that must be dropped. Each vector in the table fixes the mode inputs and then drives a full operation through both streams. The bench deliberately holds off `wreq_ready` for one cycle to exercise the stall and hold rules. It also checks that `result` has not moved before the response arrives.

// File: rtl/xrr_pkg.sv
package xrr_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } sq_state_t;

  localparam logic [31:0] SHORT_MASK_NEW = 32'hFFFF_F6FF;
  localparam logic [31:0] SHORT_MASK_OLD = 32'hFFFF_F1FF;
endpackage

// File: rtl/xrr_op_seq.sv
module xrr_op_seq
  import xrr_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [VA_W-1:0]  op_va,
  input  logic [SEL_W-1:0] op_sel,
  output logic             wreq_valid,
  input  logic             wreq_ready,
  output logic [VA_W-1:0]  wreq_va,
  output logic             wreq_write,
  output logic             wreq_user,
  input  logic             wrsp_valid,
  output logic             wrsp_ready,
  output logic             load
);
  sq_state_t state_q;
  logic [VA_W-1:0] va_q;
  logic            wr_q;
  logic            usr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (op_valid) begin
          state_q <= SQ_REQ;
          va_q    <= op_va;
          wr_q    <= op_sel[0];
          usr_q   <= op_sel[1];
        end
        SQ_REQ:  if (wreq_ready) state_q <= SQ_WAIT;
        SQ_WAIT: if (wrsp_valid) state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign op_ready   = (state_q == SQ_IDLE);
  assign wreq_valid = (state_q == SQ_REQ);
  assign wrsp_ready = (state_q == SQ_WAIT);
  assign wreq_va    = va_q;
  assign wreq_write = wr_q;
  assign wreq_user  = usr_q;
  assign load       = wrsp_ready && wrsp_valid;

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wreq_valid && !wreq_ready |=> wreq_valid && $stable(wreq_va)
      && $stable(wreq_write) && $stable(wreq_user));

  assert_accept_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_ready |=> wreq_valid && wreq_va == $past(op_va)
      && wreq_user == $past(op_sel[1]) && wreq_write == $past(op_sel[0]));

  assert_single_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wreq_valid || wrsp_ready) |-> !op_ready);
endmodule

// File: rtl/xrr_fmt.sv
module xrr_fmt #(
  parameter int PA_W  = 40,
  parameter int ST_W  = 13,
  parameter int RES_W = 64
) (
  input  logic             long_fmt,
  input  logic             new_arch,
  input  logic             fault,
  input  logic             super_sec,
  input  logic [ST_W-1:0]  status,
  input  logic [PA_W-1:0]  pa,
  output logic [RES_W-1:0] value
);
  localparam int PG_LSB = 12;
  localparam int SS_LSB = 24;
  localparam int SHORT_TOP = 31;

  always_comb begin
    value = '0;
    if (long_fmt) begin
      value[11] = 1'b1;
      if (fault) begin
        value[0]   = 1'b1;
        value[6:1] = status[5:0];
      end else begin
        value[PA_W-1:PG_LSB] = pa[PA_W-1:PG_LSB];
      end
    end else if (fault) begin
      value[0]   = 1'b1;
      value[4:1] = status[3:0];
      value[5]   = status[10];
      value[6]   = status[12];
    end else if (super_sec && new_arch) begin
      value[SHORT_TOP:SS_LSB] = pa[SHORT_TOP:SS_LSB];
      value[1] = 1'b1;
    end else begin
      value[SHORT_TOP:PG_LSB] = pa[SHORT_TOP:PG_LSB];
    end
  end
endmodule

// File: rtl/xrr_store.sv
module xrr_store
  import xrr_pkg::*;
#(
  parameter int RES_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             long_fmt,
  input  logic             new_arch,
  input  logic             load,
  input  logic [RES_W-1:0] load_val,
  input  logic             wr32,
  input  logic             wr64,
  input  logic [RES_W-1:0] wdata,
  output logic [RES_W-1:0] result
);
  localparam int HALF = RES_W / 2;

  logic [HALF-1:0] lo_mask;
  logic [RES_W-1:0] reg_q;

  assign lo_mask = long_fmt ? '1 : (new_arch ? SHORT_MASK_NEW : SHORT_MASK_OLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q <= '0;
    end else if (load) begin
      reg_q <= load_val;
    end else if (wr64) begin
      reg_q <= wdata;
    end else if (wr32) begin
      reg_q[HALF-1:0] <= wdata[HALF-1:0] & lo_mask;
    end
  end

  assign result = reg_q;

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !wr32 && !wr64 |=> $stable(result));

  assert_long_bit11_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load && long_fmt |=> result[11]);

  assert_wr64_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr64 && !load |=> result == $past(wdata));

  assert_wr32_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr32 && !wr64 && !load |=> result[RES_W-1:HALF] == $past(result[RES_W-1:HALF]));
endmodule

// File: rtl/xlat_result_reg.sv
module xlat_result_reg #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 40,
  parameter int ST_W  = 13,
  parameter int RES_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             long_fmt,
  input  logic             new_arch,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [VA_W-1:0]  op_va,
  input  logic [1:0]       op_sel,
  output logic             wreq_valid,
  input  logic             wreq_ready,
  output logic [VA_W-1:0]  wreq_va,
  output logic             wreq_write,
  output logic             wreq_user,
  input  logic             wrsp_valid,
  output logic             wrsp_ready,
  input  logic             wrsp_fault,
  input  logic             wrsp_super,
  input  logic [ST_W-1:0]  wrsp_status,
  input  logic [PA_W-1:0]  wrsp_pa,
  input  logic             reg_wr32,
  input  logic             reg_wr64,
  input  logic [RES_W-1:0] reg_wdata,
  output logic [RES_W-1:0] result
);
  logic             load;
  logic [RES_W-1:0] fmt_val;

  xrr_op_seq #(.VA_W(VA_W), .SEL_W(2)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_ready(op_ready), .op_va(op_va), .op_sel(op_sel),
    .wreq_valid(wreq_valid), .wreq_ready(wreq_ready), .wreq_va(wreq_va),
    .wreq_write(wreq_write), .wreq_user(wreq_user),
    .wrsp_valid(wrsp_valid), .wrsp_ready(wrsp_ready), .load(load)
  );

  xrr_fmt #(.PA_W(PA_W), .ST_W(ST_W), .RES_W(RES_W)) u_fmt (
    .long_fmt(long_fmt), .new_arch(new_arch), .fault(wrsp_fault),
    .super_sec(wrsp_super), .status(wrsp_status), .pa(wrsp_pa), .value(fmt_val)
  );

  xrr_store #(.RES_W(RES_W)) u_store (
    .clk(clk), .rst_n(rst_n), .long_fmt(long_fmt), .new_arch(new_arch),
    .load(load), .load_val(fmt_val), .wr32(reg_wr32), .wr64(reg_wr64),
    .wdata(reg_wdata), .result(result)
  );
endmodule

// File: tb/xlat_result_reg_test.sv
module xlat_result_reg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic long_fmt = 1'b0, new_arch = 1'b0;
  logic op_valid = 1'b0;
  logic op_ready;
  logic [31:0] op_va = '0;
  logic [1:0] op_sel = '0;
  logic wreq_valid, wreq_ready = 1'b0;
  logic [31:0] wreq_va;
  logic wreq_write, wreq_user;
  logic wrsp_valid = 1'b0, wrsp_ready;
  logic wrsp_fault = 1'b0, wrsp_super = 1'b0;
  logic [12:0] wrsp_status = '0;
  logic [39:0] wrsp_pa = '0;
  logic reg_wr32 = 1'b0, reg_wr64 = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] result;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [63:0] prev;

  always #10 clk = ~clk;

  xlat_result_reg uut (
    .clk(clk), .rst_n(rst_n), .long_fmt(long_fmt), .new_arch(new_arch),
    .op_valid(op_valid), .op_ready(op_ready), .op_va(op_va), .op_sel(op_sel),
    .wreq_valid(wreq_valid), .wreq_ready(wreq_ready), .wreq_va(wreq_va),
    .wreq_write(wreq_write), .wreq_user(wreq_user),
    .wrsp_valid(wrsp_valid), .wrsp_ready(wrsp_ready), .wrsp_fault(wrsp_fault),
    .wrsp_super(wrsp_super), .wrsp_status(wrsp_status), .wrsp_pa(wrsp_pa),
    .reg_wr32(reg_wr32), .reg_wr64(reg_wr64), .reg_wdata(reg_wdata),
    .result(result)
  );

  typedef struct packed {
    logic        lf;
    logic        na;
    logic        ft;
    logic        sp;
    logic [1:0]  sel;
    logic [12:0] st;
    logic [39:0] pa;
    logic [31:0] va;
    logic [63:0] exp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 13'h0000, 40'hAB_1234_5678, 32'h1000_0000, 64'h0000_00AB_1234_5800},
    '{1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 13'h1FE5, 40'h00_0000_0000, 32'hFFFF_F000, 64'h0000_0000_0000_084B},
    '{1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 13'h0000, 40'hFF_8765_4321, 32'h8000_0004, 64'h0000_0000_8765_4000},
    '{1'b0, 1'b1, 1'b0, 1'b1, 2'd3, 13'h0000, 40'h12_3456_7890, 32'h0123_4567, 64'h0000_0000_3400_0002},
    '{1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 13'h0000, 40'h12_3456_7890, 32'h7654_3210, 64'h0000_0000_3456_7000},
    '{1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 13'h1505, 40'hFF_FFFF_FFFF, 32'hDEAD_0000, 64'h0000_0000_0000_006B},
    '{1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 13'h000F, 40'h00_0000_0000, 32'h0000_BEEF, 64'h0000_0000_0000_001F},
    '{1'b1, 1'b1, 1'b0, 1'b1, 2'd3, 13'h0000, 40'h00_0000_1FFF, 32'h5555_AAAA, 64'h0000_0000_0000_1800}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input vec_t v);
    long_fmt = v.lf; new_arch = v.na;
    @(negedge clk);
    chk(op_ready === 1'b1, "R3 ready idle", {63'd0, op_ready}, 64'd1);
    op_valid = 1'b1; op_va = v.va; op_sel = v.sel;
    @(negedge clk);
    op_valid = 1'b0; op_va = '0; op_sel = '0;
    chk(wreq_valid === 1'b1 && wreq_va === v.va && wreq_write === v.sel[0] && wreq_user === v.sel[1],
        "R2 request", {30'd0, wreq_valid, wreq_write, wreq_user, wreq_va}, {31'd1, v.sel[0], v.sel[1], v.va});
    chk(op_ready === 1'b0, "R3 stall", {63'd0, op_ready}, 64'd0);
    @(negedge clk);
    chk(wreq_valid === 1'b1 && wreq_va === v.va, "R2 hold", {31'd0, wreq_valid, wreq_va}, {31'd1, v.va});
    wreq_ready = 1'b1;
    @(negedge clk);
    wreq_ready = 1'b0;
    chk(wreq_valid === 1'b0 && wrsp_ready === 1'b1 && op_ready === 1'b0, "R3 wait",
        {61'd0, wreq_valid, wrsp_ready, op_ready}, 64'd2);
    chk(result === prev, "R4 unchanged before response", result, prev);
    wrsp_valid = 1'b1; wrsp_fault = v.ft; wrsp_super = v.sp; wrsp_status = v.st; wrsp_pa = v.pa;
    @(negedge clk);
    wrsp_valid = 1'b0; wrsp_fault = 1'b0; wrsp_super = 1'b0; wrsp_status = '0; wrsp_pa = '0;
    chk(result === v.exp, "R4 R5 R6 R7 R8 R9 encoded result", result, v.exp);
    chk(op_ready === 1'b1, "R3 ready after response", {63'd0, op_ready}, 64'd1);
    prev = result;
  endtask

  task automatic wr(input bit w32, input bit w64, input logic [63:0] d);
    @(negedge clk);
    reg_wr32 = w32; reg_wr64 = w64; reg_wdata = d;
    @(negedge clk);
    reg_wr32 = 1'b0; reg_wr64 = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(result === 64'd0, "R1 reset result", result, 64'd0);
    chk(op_ready === 1'b1 && wreq_valid === 1'b0 && wrsp_ready === 1'b0, "R1 reset handshakes",
        {61'd0, op_ready, wreq_valid, wrsp_ready}, 64'd4);
    // R12 64-bit write
    wr(1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    chk(result === 64'hFFFF_FFFF_FFFF_FFFF, "R12 wr64 all ones", result, 64'hFFFF_FFFF_FFFF_FFFF);
    prev = result;
    for (int i = 0; i < 8; i++) run_op(VEC[i]);

    // R12 both halves
    wr(1'b0, 1'b1, 64'h1122_3344_5566_7788);
    chk(result === 64'h1122_3344_5566_7788, "R12 wr64 pattern", result, 64'h1122_3344_5566_7788);
    // R10 long 32-bit write unmasked
    long_fmt = 1'b1; new_arch = 1'b1;
    wr(1'b1, 1'b0, 64'hDEAD_BEEF_FFFF_FFFF);
    chk(result === 64'h1122_3344_FFFF_FFFF, "R10 wr32 long", result, 64'h1122_3344_FFFF_FFFF);
    // R11 short masks
    long_fmt = 1'b0; new_arch = 1'b1;
    wr(1'b1, 1'b0, 64'h0000_0000_FFFF_FFFF);
    chk(result === 64'h1122_3344_FFFF_F6FF, "R11 wr32 short new", result, 64'h1122_3344_FFFF_F6FF);
    new_arch = 1'b0;
    wr(1'b1, 1'b0, 64'h0000_0000_FFFF_FFFF);
    chk(result === 64'h1122_3344_FFFF_F1FF, "R11 wr32 short old", result, 64'h1122_3344_FFFF_F1FF);
    // R12 wr64 beats wr32
    wr(1'b1, 1'b1, 64'hA5A5_0000_0000_5A5A);
    chk(result === 64'hA5A5_0000_0000_5A5A, "R12 wr64 priority", result, 64'hA5A5_0000_0000_5A5A);
    // R1 reset again clears both halves
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(result === 64'd0, "R1 reset clears", result, 64'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule